// File: doc/BRIEF.md
# DRAM Cycle Decoder with Refresh Counter and Compare Test Mode

This block is the device-side control of an asynchronous 1M x 4 dynamic memory. It runs in a fast local clock domain. The row strobe, column strobe and write enable pass through a two-flop synchronizer, and so does the 10-bit multiplexed address. On every row-strobe falling edge the block classifies the cycle from the column-strobe and write-enable levels in the sample taken just before that edge. The classes are a normal access, a refresh from the internal row counter, or a refresh that also enters a bit-compare test mode.

The row for an access comes from the address pins. The row for a refresh comes from a 10-bit counter, which steps after each use. Within an access, every column-strobe fall latches a column, so page-mode bursts work. A refresh cycle whose column strobe is raised long enough and then dropped again becomes a counter-check cycle. That cycle reads or writes at the row the counter has just refreshed. The block drives write enables for the two cells of a pair, where the pair is selected by column bit 0. It also forms the read data from the pair: either the selected cell, or in test mode a per-bit match flag.

Top module: `dram_cycle_ctrl`

## Requirements
- R1: A row-strobe fall with the column strobe high loads `rowAddr` from the address pins and gives one `rowStb` pulse. No `refreshStb` pulse occurs.
- R2: A row-strobe fall with the column strobe already low and write enable high is a refresh. `rowAddr` takes the counter value, `rowStb` and `refreshStb` each pulse once, and the counter then advances by one.
- R3: The refresh counter is 0 after reset and wraps from 1023 to 0.
- R4: A row-strobe fall with both column strobe and write enable already low performs a counter refresh and sets `testMode`.
- R5: In test mode, a further compare-entry refresh keeps `testMode` set. A plain counter refresh clears it. A row-strobe-only cycle, with no column-strobe fall, clears it. An access that contains a column-strobe fall leaves it set.
- R6: In an access cycle, each column-strobe fall while the row strobe is low gives one `colStb` pulse and latches `colAddr`. `colWrite` is 1 when write enable was low at that fall, so several columns can be accessed under one row.
- R7: In normal mode, a write asserts only `wrEvenEn` when column bit 0 is 0, and only `wrOddEn` when it is 1. A read returns `pairEven` or `pairOdd`, chosen by the same bit, on `dataOut`, and sets `dataValid`.
- R8: In test mode, a write asserts both `wrEvenEn` and `wrOddEn`. A read returns, per bit, 1 where `pairEven` and `pairOdd` agree and 0 where they differ.
- R9: In a refresh cycle, a column-strobe fall gives a `colStb` at the refreshed row only if the column strobe was high for at least `CPT_CYC` (default 4) clock cycles before it. A shorter high gives no `colStb`.
- R10: If the column strobe stays low after a read while the row strobe rises and falls again, that cycle is a counter refresh. `dataValid` and `dataOut` keep the read value throughout.
- R11: `dataValid` drops after the column strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rstN | input | 1 | Active-low power-on reset |
| rasN | input | 1 | Row strobe, active low, asynchronous |
| casN | input | 1 | Column strobe, active low, asynchronous |
| weN | input | 1 | Write enable, active low, asynchronous |
| addr | input | 10 | Multiplexed row/column address |
| pairEven | input | 4 | Array read of the cell pair member with column bit 0 = 0 |
| pairOdd | input | 4 | Array read of the cell pair member with column bit 0 = 1 |
| rowAddr | output | 10 | Row to activate |
| rowStb | output | 1 | One-cycle pulse when a row is opened |
| refreshStb | output | 1 | One-cycle pulse when the opened row came from the counter |
| colAddr | output | 10 | Latched column |
| colStb | output | 1 | One-cycle pulse when a column is latched |
| colWrite | output | 1 | The latched column access is a write |
| wrEvenEn | output | 1 | Write pulse for the even cell of the pair |
| wrOddEn | output | 1 | Write pulse for the odd cell of the pair |
| dataOut | output | 4 | Read data or per-bit compare result |
| dataValid | output | 1 | Read data is being driven |
| testMode | output | 1 | Compare test mode active |

## Verification
A counter that is off by one shows up at the very next refresh as a wrong `rowAddr`. It also shows up in a counter-check write that lands in a row where a later normal read does not find the data. A wrong test-mode flag changes the next read within a few cycles: the result is a match mask instead of a cell value, or a single cell instead of a mask. A wrong flag also changes the next write, which enables the wrong number of cells. A wrong cycle class is seen within about three clocks of the row-strobe fall, as a refresh pulse that is missing or extra.

// File: rtl/dram_ctl_pkg.sv
package dram_ctl_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE = 2'd0,
    CYC_NORM = 2'd1,
    CYC_REFR = 2'd2
  } cycState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic rowLoad;
    logic rowFromCnt;
    logic colLoad;
    logic colWr;
    logic casRise;
    logic test;
  } ctlStrobes_t;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= {W{RST_VAL}};
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dram_cyc_ctrl.sv
module dram_cyc_ctrl
  import dram_ctl_pkg::*;
#(
  parameter int CPT_CYC = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rasS,
  input  logic        casS,
  input  logic        weS,
  output ctlStrobes_t ctl,
  output logic        testMode
);
  localparam int HCNT_W = $clog2(CPT_CYC + 1);
  localparam logic [HCNT_W-1:0] HCNT_MAX = HCNT_W'(CPT_CYC);

  cycState_t state;
  logic rasP, casP, weP;
  logic [HCNT_W-1:0] hiCnt;
  logic casSeen;
  logic rasFall, rasRise, casFall, casRise, colOk;

  assign rasFall = rasP & ~rasS;
  assign rasRise = ~rasP & rasS;
  assign casFall = casP & ~casS;
  assign casRise = ~casP & casS;
  assign colOk   = (state == CYC_NORM) || (state == CYC_REFR && hiCnt == HCNT_MAX);

  always_comb begin
    ctl.rowLoad    = rasFall;
    ctl.rowFromCnt = ~casP;
    ctl.colLoad    = ~rasS & casFall & colOk;
    ctl.colWr      = ~weS;
    ctl.casRise    = casRise;
    ctl.test       = testMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rasP <= 1'b1; casP <= 1'b1; weP <= 1'b1;
      state <= CYC_IDLE;
      hiCnt <= '0;
      casSeen <= 1'b0;
      testMode <= 1'b0;
    end else begin
      rasP <= rasS; casP <= casS; weP <= weS;
      if (rasFall) begin
        state <= casP ? CYC_NORM : CYC_REFR;
        hiCnt <= '0;
        casSeen <= 1'b0;
        if (!casP) testMode <= ~weP;
      end else if (rasRise) begin
        state <= CYC_IDLE;
        if (state == CYC_NORM && !casSeen) testMode <= 1'b0;
      end else begin
        if (casFall) casSeen <= 1'b1;
        if (state == CYC_REFR) begin
          if (casFall) hiCnt <= '0;
          else if (casS && hiCnt != HCNT_MAX) hiCnt <= hiCnt + 1'b1;
        end
      end
    end
  end

  // R6: columns only while a row is open
  a_r6_col_in_ras: assert property (@(posedge clk) disable iff (!rstN)
    ctl.colLoad |-> (!rasS && state != CYC_IDLE));
  // R4: compare-entry refresh sets test mode
  a_r4_wcbr_enter: assert property (@(posedge clk) disable iff (!rstN)
    (rasFall && !casP && !weP) |=> testMode);
  // R5: row-strobe-only cycle leaves test mode
  a_r5_rasonly_exit: assert property (@(posedge clk) disable iff (!rstN)
    (rasRise && state == CYC_NORM && !casSeen) |=> !testMode);
  // R9: counter-check column needs the full high gap
  a_r9_check_gap: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.colLoad && state == CYC_REFR) |-> $past(casS));
endmodule

// File: rtl/dram_row_col_path.sv
module dram_row_col_path
  import dram_ctl_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int IO_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic [ADDR_W-1:0] addrS,
  input  logic [IO_W-1:0]   pairEven,
  input  logic [IO_W-1:0]   pairOdd,
  output logic [ADDR_W-1:0] rowAddr,
  output logic              rowStb,
  output logic              refreshStb,
  output logic [ADDR_W-1:0] colAddr,
  output logic              colStb,
  output logic              colWrite,
  output logic              wrEvenEn,
  output logic              wrOddEn,
  output logic [IO_W-1:0]   dataOut,
  output logic              dataValid
);
  logic [ADDR_W-1:0] cnt;
  logic rdTest;
  logic doRead;

  assign doRead = colStb & ~colWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0; rowAddr <= '0; colAddr <= '0;
      rowStb <= 1'b0; refreshStb <= 1'b0; colStb <= 1'b0; colWrite <= 1'b0;
      wrEvenEn <= 1'b0; wrOddEn <= 1'b0; rdTest <= 1'b0;
      dataOut <= '0; dataValid <= 1'b0;
    end else begin
      rowStb     <= ctl.rowLoad;
      refreshStb <= ctl.rowLoad & ctl.rowFromCnt;
      colStb     <= ctl.colLoad;
      wrEvenEn   <= ctl.colLoad & ctl.colWr & (ctl.test | ~addrS[0]);
      wrOddEn    <= ctl.colLoad & ctl.colWr & (ctl.test |  addrS[0]);
      if (ctl.rowLoad) begin
        rowAddr <= ctl.rowFromCnt ? cnt : addrS;
        if (ctl.rowFromCnt) cnt <= cnt + 1'b1;
      end
      if (ctl.colLoad) begin
        colAddr  <= addrS;
        colWrite <= ctl.colWr;
        rdTest   <= ctl.test;
      end
      if (doRead) begin
        dataOut   <= rdTest ? ~(pairEven ^ pairOdd) : (colAddr[0] ? pairOdd : pairEven);
        dataValid <= 1'b1;
      end else if (ctl.casRise) begin
        dataValid <= 1'b0;
      end
    end
  end

  // R2: counter steps once per refresh
  a_r2_cnt_step: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.rowLoad && ctl.rowFromCnt) |=> cnt == $past(cnt) + 1'b1);
  // R3: counter holds otherwise
  a_r3_cnt_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.rowLoad && ctl.rowFromCnt) |=> cnt == $past(cnt));
  // R1: refresh pulse always comes with a row pulse
  a_r1_refresh_has_row: assert property (@(posedge clk) disable iff (!rstN)
    refreshStb |-> rowStb);
  // R8: both cells written only in test mode
  a_r8_both_only_test: assert property (@(posedge clk) disable iff (!rstN)
    (wrEvenEn && wrOddEn) |-> $past(ctl.test));
  // R11: output released after the column strobe rises
  a_r11_valid_drop: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.casRise && !doRead) |=> !dataValid);
endmodule

// File: rtl/dram_cycle_ctrl.sv
module dram_cycle_ctrl
  import dram_ctl_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int IO_W = 4,
  parameter int SYNC_STAGES = 2,
  parameter int CPT_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [IO_W-1:0]   pairEven,
  input  logic [IO_W-1:0]   pairOdd,
  output logic [ADDR_W-1:0] rowAddr,
  output logic              rowStb,
  output logic              refreshStb,
  output logic [ADDR_W-1:0] colAddr,
  output logic              colStb,
  output logic              colWrite,
  output logic              wrEvenEn,
  output logic              wrOddEn,
  output logic [IO_W-1:0]   dataOut,
  output logic              dataValid,
  output logic              testMode
);
  logic [2:0] strobeS;
  logic [ADDR_W-1:0] addrS;
  ctlStrobes_t ctl;

  strobe_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) uStrobeSync (
    .clk(clk), .rstN(rstN), .d({rasN, casN, weN}), .q(strobeS));

  strobe_sync #(.W(ADDR_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) uAddrSync (
    .clk(clk), .rstN(rstN), .d(addr), .q(addrS));

  dram_cyc_ctrl #(.CPT_CYC(CPT_CYC)) uCtrl (
    .clk(clk), .rstN(rstN),
    .rasS(strobeS[2]), .casS(strobeS[1]), .weS(strobeS[0]),
    .ctl(ctl), .testMode(testMode));

  dram_row_col_path #(.ADDR_W(ADDR_W), .IO_W(IO_W)) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .addrS(addrS),
    .pairEven(pairEven), .pairOdd(pairOdd),
    .rowAddr(rowAddr), .rowStb(rowStb), .refreshStb(refreshStb),
    .colAddr(colAddr), .colStb(colStb), .colWrite(colWrite),
    .wrEvenEn(wrEvenEn), .wrOddEn(wrOddEn),
    .dataOut(dataOut), .dataValid(dataValid));
endmodule

// File: tb/tb_dram_cycle_ctrl.sv
module tb_dram_cycle_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [9:0] addr = '0;
  logic [3:0] pairEven = '0, pairOdd = '0, din = '0;
  logic [9:0] rowAddr, colAddr;
  logic rowStb, refreshStb, colStb, colWrite, wrEvenEn, wrOddEn, dataValid, testMode;
  logic [3:0] dataOut;

  dram_cycle_ctrl dut (
    .clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN), .weN(weN), .addr(addr),
    .pairEven(pairEven), .pairOdd(pairOdd), .rowAddr(rowAddr), .rowStb(rowStb),
    .refreshStb(refreshStb), .colAddr(colAddr), .colStb(colStb), .colWrite(colWrite),
    .wrEvenEn(wrEvenEn), .wrOddEn(wrOddEn), .dataOut(dataOut), .dataValid(dataValid),
    .testMode(testMode));

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0, nErrors = 0;
  int rowCnt = 0, refCnt = 0, colCnt = 0, evenCnt = 0, oddCnt = 0;
  logic [9:0] lastRow = '0;
  logic [3:0] store [int];
  logic [3:0] shadow [int];
  logic [9:0] expCnt = '0;
  bit done = 0;

  function automatic int keyOf(logic [9:0] r, logic [9:0] c, bit side);
    return (int'(r) << 10) | (int'(c[9:1]) << 1) | int'(side);
  endfunction
  function automatic logic [3:0] rdStore(int k);
    return store.exists(k) ? store[k] : 4'h0;
  endfunction
  function automatic logic [3:0] rdShadow(int k);
    return shadow.exists(k) ? shadow[k] : 4'h0;
  endfunction

  // behavioural array and pulse monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      if (rowStb) begin rowCnt++; lastRow = rowAddr; end
      if (refreshStb) refCnt++;
      if (colStb) colCnt++;
      if (wrEvenEn) begin evenCnt++; store[keyOf(rowAddr, colAddr, 1'b0)] = din; end
      if (wrOddEn)  begin oddCnt++;  store[keyOf(rowAddr, colAddr, 1'b1)] = din; end
    end
    pairEven = rdStore(keyOf(rowAddr, colAddr, 1'b0));
    pairOdd  = rdStore(keyOf(rowAddr, colAddr, 1'b1));
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // access cycle: one column, returns read data
  task automatic access(logic [9:0] r, logic [9:0] c, bit wr, logic [3:0] d, output logic [3:0] q);
    addr = r; tick(2); rasN = 1'b0; tick(5);
    addr = c; weN = ~wr; din = d; tick(2); casN = 1'b0; tick(5);
    q = dataOut;
    casN = 1'b1; weN = 1'b1; tick(3); rasN = 1'b1; tick(5);
  endtask

  task automatic refresh(bit wcbr);
    casN = 1'b0; weN = ~wcbr; tick(3); rasN = 1'b0; tick(5);
    rasN = 1'b1; tick(3); casN = 1'b1; weN = 1'b1; tick(4);
  endtask

  task automatic rasOnly(logic [9:0] r);
    addr = r; tick(2); rasN = 1'b0; tick(5); rasN = 1'b1; tick(5);
  endtask

  logic [3:0] q, v;
  int r0, c0, k;

  initial begin
    tick(3); rstN = 1'b1; tick(3);
    // reset state
    chk("R3 reset rowAddr", rowAddr, 0);
    chk("R4 reset testMode", testMode, 0);
    chk("R11 reset dataValid", dataValid, 0);

    // R3 first refresh uses row 0; R2 step
    r0 = refCnt; refresh(0);
    chk("R3 first refresh row", lastRow, 0);
    chk("R2 refresh pulse", refCnt - r0, 1);
    refresh(0);
    chk("R2 counter advanced", lastRow, 1);
    expCnt = 10'd2;

    // R1 normal row from pins, no refresh pulse
    r0 = refCnt; k = rowCnt;
    access(10'd37, 10'd4, 1'b1, 4'h5, q);
    chk("R1 row from pins", lastRow, 37);
    chk("R1 single row pulse", rowCnt - k, 1);
    chk("R1 no refresh pulse", refCnt - r0, 0);
    shadow[keyOf(10'd37, 10'd4, 1'b0)] = 4'h5;

    // R7 even/odd selection by column bit 0
    k = oddCnt;
    access(10'd37, 10'd5, 1'b1, 4'h9, q);
    shadow[keyOf(10'd37, 10'd5, 1'b1)] = 4'h9;
    chk("R7 odd write only odd", oddCnt - k, 1);
    access(10'd37, 10'd4, 1'b0, 4'h0, q);
    chk("R7 even read", q, 4'h5);
    access(10'd37, 10'd5, 1'b0, 4'h0, q);
    chk("R7 odd read", q, 4'h9);

    // R6 page mode: three columns under one row
    k = colCnt; r0 = rowCnt;
    addr = 10'd40; tick(2); rasN = 1'b0; tick(5);
    for (int i = 0; i < 3; i++) begin
      addr = 10'(8 + i); weN = (i != 1); din = 4'hC; tick(2);
      casN = 1'b0; tick(5);
      if (i == 1) chk("R6 colWrite on WE low", colWrite, 1);
      else chk("R6 colWrite on WE high", colWrite, 0);
      casN = 1'b1; weN = 1'b1; tick(3);
    end
    rasN = 1'b1; tick(5);
    chk("R6 three column pulses", colCnt - k, 3);
    chk("R6 one row pulse", rowCnt - r0, 1);
    shadow[keyOf(10'd40, 10'd9, 1'b1)] = 4'hC;

    // R4 enter test mode with a counter refresh
    r0 = refCnt; refresh(1);
    chk("R4 testMode set", testMode, 1);
    chk("R4 refresh row", lastRow, expCnt); expCnt++;
    chk("R4 refresh pulse", refCnt - r0, 1);

    // R8 test write fills both cells, compare reads match
    k = evenCnt + oddCnt;
    access(10'd900, 10'd20, 1'b1, 4'h6, q);
    chk("R8 both enables", evenCnt + oddCnt - k, 2);
    access(10'd900, 10'd20, 1'b0, 4'h0, q);
    chk("R8 compare all match", q, 4'hF);
    store[keyOf(10'd900, 10'd20, 1'b1)] = 4'h6 ^ 4'b0100; // faulty cell
    access(10'd900, 10'd21, 1'b0, 4'h0, q);
    chk("R8 compare one mismatch", q, 4'b1011);
    chk("R5 access keeps test mode", testMode, 1);
    refresh(1); expCnt++;
    chk("R5 second entry keeps test mode", testMode, 1);
    rasOnly(10'd3);
    chk("R5 ras-only exits test mode", testMode, 0);
    access(10'd900, 10'd20, 1'b0, 4'h0, q);
    chk("R8 even cell written in test", q, 4'h6);
    refresh(1); expCnt++;
    refresh(0); expCnt++;
    chk("R5 plain refresh exits test mode", testMode, 0);

    // R9 counter check: long high gap -> write at refreshed row
    r0 = expCnt; k = colCnt;
    casN = 1'b0; tick(3); rasN = 1'b0; tick(5); expCnt++;
    casN = 1'b1; addr = 10'd6; weN = 1'b0; din = 4'hA; tick(10);
    casN = 1'b0; tick(5);
    chk("R9 long gap column", colCnt - k, 1);
    chk("R9 row is refreshed row", lastRow, r0);
    casN = 1'b1; weN = 1'b1; tick(3); rasN = 1'b1; tick(5);
    shadow[keyOf(10'(r0), 10'd6, 1'b0)] = 4'hA;
    access(10'(r0), 10'd6, 1'b0, 4'h0, q);
    chk("R9 counter-check write landed", q, 4'hA);
    // short high gap -> no column
    k = colCnt;
    casN = 1'b0; tick(3); rasN = 1'b0; tick(5); expCnt++;
    casN = 1'b1; addr = 10'd6; tick(1);
    casN = 1'b0; tick(5);
    chk("R9 short gap no column", colCnt - k, 0);
    casN = 1'b1; tick(3); rasN = 1'b1; tick(5);

    // R10 hidden refresh keeps read data driven
    addr = 10'd37; tick(2); rasN = 1'b0; tick(5);
    addr = 10'd5; tick(2); casN = 1'b0; tick(5);
    v = dataOut;
    chk("R10 read before hide", v, 4'h9);
    rasN = 1'b1; tick(4); r0 = refCnt;
    rasN = 1'b0; tick(5);
    chk("R10 hidden refresh pulse", refCnt - r0, 1);
    chk("R10 hidden refresh row", lastRow, expCnt); expCnt++;
    chk("R10 dataValid held", dataValid, 1);
    chk("R10 dataOut held", dataOut, v);
    rasN = 1'b1; tick(3); casN = 1'b1; tick(5);
    chk("R11 dataValid dropped", dataValid, 0);

    // random mix against bench expectations
    void'($urandom(32'd20240611));
    for (int i = 0; i < 40; i++) begin
      logic [9:0] rr, cc; logic [3:0] dd; int op;
      op = $urandom % 3; rr = 10'($urandom % 8); cc = 10'($urandom % 16); dd = 4'($urandom);
      if (op == 0) begin
        access(rr, cc, 1'b1, dd, q); shadow[keyOf(rr, cc, cc[0])] = dd;
      end else if (op == 1) begin
        access(rr, cc, 1'b0, 4'h0, q);
        chk("R7 random read", q, rdShadow(keyOf(rr, cc, cc[0])));
      end else begin
        refresh(0);
        chk("R2 random refresh row", lastRow, expCnt); expCnt++;
      end
    end

    // R3 wrap 1023 -> 0
    while (expCnt != 10'd1023) begin refresh(0); expCnt++; end
    refresh(0);
    chk("R3 row 1023", lastRow, 1023);
    refresh(0);
    chk("R3 wrap to 0", lastRow, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nErrors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
      $finish;
    end
  end
endmodule